// File: doc/BRIEF.md
# Oversampled UART Receiver with Start-Byte Framing

This block takes an asynchronous 8N1 serial line (idle high, LSB first), samples it at a multiple of the bit rate and rebuilds characters. A start bit is accepted only if the line is still low at its midpoint. This lets the receiver ride through a start bit that was cut short when the previous talker on a shared half-duplex line released its driver late. A character whose stop-bit sample reads low is marked as a framing error.

A framer sits behind the character receiver and hunts for a configured start byte. While it hunts, it drops fill bytes of 0xFF, any other byte, and every character with a framing error. Once the start byte arrives, that byte and all later ones go out on a valid/ready byte port, and the start byte carries a frame-start flag. A framing error inside a frame raises an error pulse and sends the framer back to hunting. An external idle-timeout input also forces the framer back to hunting, which closes the frame between transfers.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset, m_valid_o and frame_err_o are low and the framer is hunting.
- R2: The line is sampled once per oversample tick, 16 ticks per bit by default. Data bits are taken LSB first at mid-bit. With one tick per clock, m_valid_o rises 155 clock edges after the first edge that samples rxd_i low.
- R3: A start pulse of 8 ticks or fewer (half a bit or less) is rejected as noise. A pulse of 9 ticks or more starts a character, so a 9-tick pulse on an otherwise high line yields 0xFF.
- R4: When the stop-bit sample reads low, the character is marked as a framing error.
- R5: While hunting, 0xFF and every byte that differs from sof_byte_i are discarded and never appear on the output.
- R6: While hunting, a character with a framing error is discarded without an error pulse, even if its data equals sof_byte_i.
- R7: A correctly framed byte equal to sof_byte_i ends the hunt and is forwarded with m_first_o=1. Later bytes, including 0xFF and further start-byte values, are forwarded with m_first_o=0.
- R8: Inside a frame, a framing-error character is not forwarded. It drives frame_err_o high for exactly one cycle and returns the framer to hunting.
- R9: While idle_i is high the framer returns to hunting. A character completing in the same cycle as idle_i is discarded.
- R10: A held output byte stays stable until m_ready_i is high. A character arriving while a byte is held and m_ready_i is low is discarded. A character arriving in the cycle of a handshake replaces the consumed byte.
- R11: rxd_i passes through a two-flop synchronizer (reset to idle high) before edge detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| sof_byte_i | input | 8 | Start-of-frame byte value (static) |
| idle_i | input | 1 | Idle timeout: return framer to hunting |
| m_data_o | output | 8 | Forwarded byte |
| m_first_o | output | 1 | Byte is the frame's start byte |
| m_valid_o | output | 1 | Output byte valid |
| m_ready_i | input | 1 | Consumer accepts the byte |
| frame_err_o | output | 1 | One-cycle pulse: framing error inside a frame |

## Verification
In one cycle, a character can complete at the output register while the consumer takes the byte already held there. A second collision puts a character's completion in the same cycle as the idle timeout. The bench works out the exact completion edge of each character from R2's latency. It then pulses m_ready_i, or in another run idle_i, for only the cycle before that edge. A behavioural reference model advances on every clock and is compared with the outputs after each edge. The bench then checks the logged handshakes: the new byte must survive the handshake collision, and it must be lost, with the framer left hunting, in the idle collision.

// File: rtl/uart_frame_rx_pkg.sv
package uart_frame_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  typedef enum logic {
    FRM_HUNT,
    FRM_LOCKED
  } frm_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       ferr;
  } rx_char_t;
endpackage

// File: rtl/uart_frame_rx_sync.sv
module uart_frame_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_frame_rx_sampler.sv
module uart_frame_rx_sampler
  import uart_frame_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int TICK_DIV   = 1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     line_i,
  output logic     char_valid_o,
  output rx_char_t char_o
);
  localparam int HALF = OVERSAMPLE / 2;
  localparam int CW   = $clog2(OVERSAMPLE);
  localparam int TW   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic tick;

  generate
    if (TICK_DIV > 1) begin : g_div
      logic [TW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        div_q <= '0;
        else if (div_q == TW'(TICK_DIV-1))  div_q <= '0;
        else                                div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == TW'(TICK_DIV-1));
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  rx_state_e  state_q;
  logic [CW-1:0] cnt_q;
  logic [2:0] bit_q;
  logic [7:0] shreg_q;
  logic       prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= RX_IDLE;
      cnt_q        <= '0;
      bit_q        <= '0;
      shreg_q      <= '0;
      prev_q       <= 1'b1;
      char_valid_o <= 1'b0;
      char_o       <= '0;
    end else begin
      char_valid_o <= 1'b0;
      if (tick) begin
        prev_q <= line_i;
        unique case (state_q)
          RX_IDLE: begin
            // falling edge only: a line held low after a bad stop is not a start
            if (prev_q && !line_i) begin
              state_q <= RX_START;
              cnt_q   <= '0;
            end
          end
          RX_START: begin
            if (cnt_q == CW'(HALF-1)) begin
              cnt_q <= '0;
              bit_q <= '0;
              state_q <= line_i ? RX_IDLE : RX_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt_q == CW'(OVERSAMPLE-1)) begin
              cnt_q   <= '0;
              shreg_q <= {line_i, shreg_q[7:1]};
              if (bit_q == 3'd7) state_q <= RX_STOP;
              else               bit_q   <= bit_q + 3'd1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt_q == CW'(OVERSAMPLE-1)) begin
              cnt_q        <= '0;
              char_valid_o <= 1'b1;
              char_o.data  <= shreg_q;
              char_o.ferr  <= ~line_i;
              state_q      <= RX_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  p_one_shot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_o |=> !char_valid_o);

  p_emit_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_o |-> (state_q == RX_IDLE));
endmodule

// File: rtl/uart_frame_rx_framer.sv
module uart_frame_rx_framer
  import uart_frame_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idle_i,
  input  logic [7:0] sof_byte_i,
  input  logic       char_valid_i,
  input  rx_char_t   char_i,
  output logic [7:0] m_data_o,
  output logic       m_first_o,
  output logic       m_valid_o,
  input  logic       m_ready_i,
  output logic       frame_err_o
);
  frm_state_e state_q;
  logic slot_free;

  assign slot_free = !m_valid_o || m_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= FRM_HUNT;
      m_data_o    <= '0;
      m_first_o   <= 1'b0;
      m_valid_o   <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      frame_err_o <= 1'b0;
      if (m_valid_o && m_ready_i) m_valid_o <= 1'b0;
      if (idle_i) begin
        state_q <= FRM_HUNT;
      end else if (char_valid_i) begin
        if (state_q == FRM_HUNT) begin
          if (!char_i.ferr && char_i.data == sof_byte_i) begin
            state_q <= FRM_LOCKED;
            if (slot_free) begin
              m_valid_o <= 1'b1;
              m_data_o  <= char_i.data;
              m_first_o <= 1'b1;
            end
          end
        end else if (char_i.ferr) begin
          frame_err_o <= 1'b1;
          state_q     <= FRM_HUNT;
        end else if (slot_free) begin
          m_valid_o <= 1'b1;
          m_data_o  <= char_i.data;
          m_first_o <= 1'b0;
        end
      end
    end
  end

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o) && $stable(m_first_o)));

  p_first_is_sof_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && m_first_o) |-> (m_data_o == sof_byte_i));

  p_idle_hunt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |=> (state_q == FRM_HUNT && !frame_err_o));

  p_err_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> (state_q == FRM_HUNT) ##1 !frame_err_o);

  p_hunt_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FRM_HUNT && char_valid_i && char_i.ferr) |=> !frame_err_o);
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_frame_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int TICK_DIV    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rxd_i,
  input  logic [7:0] sof_byte_i,
  input  logic       idle_i,
  output logic [7:0] m_data_o,
  output logic       m_first_o,
  output logic       m_valid_o,
  input  logic       m_ready_i,
  output logic       frame_err_o
);
  logic     line_s;
  logic     char_valid;
  rx_char_t char_d;

  uart_frame_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rxd_i),
    .q_o    (line_s)
  );

  uart_frame_rx_sampler #(
    .OVERSAMPLE (OVERSAMPLE),
    .TICK_DIV   (TICK_DIV)
  ) u_sampler (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_i       (line_s),
    .char_valid_o (char_valid),
    .char_o       (char_d)
  );

  uart_frame_rx_framer u_framer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .idle_i       (idle_i),
    .sof_byte_i   (sof_byte_i),
    .char_valid_i (char_valid),
    .char_i       (char_d),
    .m_data_o     (m_data_o),
    .m_first_o    (m_first_o),
    .m_valid_o    (m_valid_o),
    .m_ready_i    (m_ready_i),
    .frame_err_o  (frame_err_o)
  );

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!m_valid_o && !frame_err_o));
endmodule

// File: tb/uart_frame_rx_bench.sv
module uart_frame_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OS         = 16;
  localparam int LAT        = 156;
  localparam int MIN_START  = OS/2 + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       idle = 1'b0;
  logic       ready = 1'b1;
  logic [7:0] sof = 8'h68;
  logic [7:0] m_data;
  logic       m_first, m_valid, frame_err;

  uart_frame_rx u_uart_frame_rx (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rxd_i       (rxd),
    .sof_byte_i  (sof),
    .idle_i      (idle),
    .m_data_o    (m_data),
    .m_first_o   (m_first),
    .m_valid_o   (m_valid),
    .m_ready_i   (ready),
    .frame_err_o (frame_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed { int at; logic [7:0] d; logic ferr; } ev_t;
  typedef struct packed { logic [7:0] d; logic f; } out_t;

  ev_t  evq[$];
  out_t got[$];
  int   cyc = 0, checks = 0, fails = 0, errcnt = 0;
  bit   running = 0;

  // reference model state
  bit         md_v = 0, md_f = 0, md_e = 0, md_lock = 0, md_pop, md_ev;
  logic [7:0] md_d = 8'h00;
  ev_t        md_cur;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      md_v = 0; md_f = 0; md_e = 0; md_lock = 0;
    end else begin
      md_pop = md_v && ready;
      md_ev  = 0;
      if (evq.size() > 0 && evq[0].at == cyc) begin
        md_cur = evq.pop_front();
        md_ev  = 1;
      end
      md_e = 0;
      if (md_pop) md_v = 0;
      if (idle) md_lock = 0;
      else if (md_ev) begin
        if (!md_lock) begin
          if (!md_cur.ferr && md_cur.d == sof) begin
            md_lock = 1;
            if (!md_v) begin md_v = 1; md_d = md_cur.d; md_f = 1; end
          end
        end else if (md_cur.ferr) begin
          md_e = 1; md_lock = 0;
        end else if (!md_v) begin
          md_v = 1; md_d = md_cur.d; md_f = 0;
        end
      end
    end
  end

  // per-clock comparison and handshake log
  always @(negedge clk) begin
    if (running) begin
      chk("R2 R10 model valid", {31'b0, m_valid}, {31'b0, md_v});
      if (md_v) begin
        chk("R2 R7 model data", {24'b0, m_data}, {24'b0, md_d});
        chk("R7 model first", {31'b0, m_first}, {31'b0, md_f});
      end
      chk("R8 model err", {31'b0, frame_err}, {31'b0, md_e});
      if (m_valid && ready) got.push_back('{d: m_data, f: m_first});
      if (frame_err) errcnt++;
    end
  end

  // drive one character; slen = start-bit length in ticks
  task automatic send(logic [7:0] d, logic stop, int slen);
    for (int t = 0; t < 10*OS; t++) begin
      @(negedge clk);
      if (t == 0 && slen >= MIN_START)
        evq.push_back('{at: cyc + LAT, d: (slen < OS) ? 8'hFF : d,
                        ferr: (slen < OS) ? 1'b0 : ~stop});
      if (t < slen)           rxd = 1'b0;
      else if (slen < OS)     rxd = 1'b1;
      else if (t / OS <= 8)   rxd = d[t/OS - 1];
      else                    rxd = stop;
    end
  endtask

  task automatic gap(int n);
    repeat (n) begin @(negedge clk); rxd = 1'b1; end
  endtask

  task automatic drain();
    gap(LAT + 10);
  endtask

  task automatic chk_got(string req, int idx, logic [7:0] d, logic f);
    if (idx >= got.size()) chk(req, 32'hDEAD, {23'b0, d, f});
    else chk(req, {23'b0, got[idx].d, got[idx].f}, {23'b0, d, f});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int at;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'b0, m_valid}, 32'd0);
    chk("R1 reset err", {31'b0, frame_err}, 32'd0);
    rst_n = 1'b1;
    running = 1;
    gap(5);
    chk("R1 idle after reset", {31'b0, m_valid}, 32'd0);

    // R5 R6: hunt drops fill, noise and bad characters
    send(8'hFF, 1, OS); send(8'hFF, 1, OS); send(8'h12, 1, OS);
    send(8'h68, 0, OS); gap(20);
    drain();
    chk("R5 nothing forwarded in hunt", got.size(), 0);
    chk("R6 no error in hunt", errcnt, 0);
    // R7: lock and forward
    send(8'h68, 1, OS); send(8'h01, 1, OS); send(8'hFF, 1, OS);
    send(8'h68, 1, OS); send(8'h7E, 1, OS);
    drain();
    chk("R7 count", got.size(), 5);
    chk_got("R7 sof first", 0, 8'h68, 1);
    chk_got("R2 data 01", 1, 8'h01, 0);
    chk_got("R7 ff in frame", 2, 8'hFF, 0);
    chk_got("R7 sof value as data", 3, 8'h68, 0);
    chk_got("R2 data 7e", 4, 8'h7E, 0);
    got.delete();

    // R4 R8: framing error in frame
    send(8'h33, 0, OS); gap(20);
    drain();
    chk("R8 one error pulse", errcnt, 1);
    chk("R8 bad byte dropped", got.size(), 0);
    send(8'h44, 1, OS);
    drain();
    chk("R8 back in hunt", got.size(), 0);
    send(8'h68, 1, OS); send(8'h55, 1, OS);
    drain();
    chk_got("R8 relock", 0, 8'h68, 1);
    chk_got("R8 relock data", 1, 8'h55, 0);
    got.delete();

    // R3: truncated start bits
    send(8'h00, 1, OS/2); gap(30);
    drain();
    chk("R3 half-bit pulse rejected", got.size(), 0);
    send(8'h00, 1, MIN_START); gap(30);
    send(8'h56, 1, OS);
    drain();
    chk("R3 count", got.size(), 2);
    chk_got("R3 truncated start accepted", 0, 8'hFF, 0);
    chk_got("R3 resync after truncation", 1, 8'h56, 0);
    got.delete();

    // R9: idle timeout, then idle in the completion cycle
    @(negedge clk); idle = 1'b1; @(negedge clk); idle = 1'b0;
    send(8'h10, 1, OS);
    drain();
    chk("R9 idle returns to hunt", got.size(), 0);
    send(8'h68, 1, OS);
    drain();
    got.delete();
    @(negedge clk);
    at = cyc + 1 + LAT;
    fork
      send(8'h21, 1, OS);
      begin
        while (cyc != at - 1) @(negedge clk);
        idle = 1'b1;
        @(negedge clk);
        idle = 1'b0;
      end
    join
    send(8'h22, 1, OS);
    drain();
    chk("R9 coincident char dropped", got.size(), 0);
    got.delete();

    // R10: hold, drop while full, handshake collision
    send(8'h68, 1, OS);
    drain();
    got.delete();
    ready = 1'b0;
    send(8'hA1, 1, OS); send(8'hB2, 1, OS);
    drain();
    chk("R10 held valid", {31'b0, m_valid}, 32'd1);
    chk("R10 held data", {24'b0, m_data}, 32'hA1);
    chk("R10 no handshake while stalled", got.size(), 0);
    @(negedge clk);
    at = cyc + 1 + LAT;
    fork
      send(8'hC3, 1, OS);
      begin
        while (cyc != at - 1) @(negedge clk);
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;
      end
    join
    gap(5);
    chk("R10 collision keeps new byte", {31'b0, m_valid}, 32'd1);
    chk("R10 collision data", {24'b0, m_data}, 32'hC3);
    ready = 1'b1;
    gap(5);
    chk("R10 count", got.size(), 2);
    chk_got("R10 first held byte", 0, 8'hA1, 0);
    chk_got("R10 byte after collision", 1, 8'hC3, 0);
    chk("R11 R2 model drained", evq.size(), 0);

    running = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule